// File: doc/BRIEF.md
# GPIO Emergency Stop Output Override

This block selects what drives each of the sixteen pins of one general-purpose I/O port. In normal running, every pin takes its value from its own configuration field. That field chooses either the software output latch or one of three alternate sources coming from a timer unit. It also sets whether the pin's output driver is on.

A global emergency stop input can take pins away from the timer. A per-pin enable mask decides which pins react. While the stop input is high, each pin whose mask bit is set is driven from its own bit of the output latch. For such a pin, the output driver is forced on and the pin's configuration field is ignored. Pins whose mask bit is clear carry on as before. The override is purely combinational, so dropping the stop input returns every pin to its configured source at once.

Software sets up the block through a small synchronous register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `gpio_estop_port`

## Requirements
- R1: After reset, every register reads zero, every pin drives 0 and every output enable is 0.
- R2: The stop-enable mask is at offset 0x50. Bits 15:0 are read/write, and bit x belongs to pin x.
- R3: Bits 31:16 of the mask register always read zero, and writing ones to them changes nothing.
- R4: The output latch is at offset 0x00. Bits 15:0 are read/write, bit x belongs to pin x, and bits 31:16 read zero.
- R5: Two 32-bit configuration registers hold eight 4-bit fields each: offset 0x10 for pins 0-7 and offset 0x14 for pins 8-15. The field of pin p sits at bits 4*(p mod 8)+3 down to 4*(p mod 8). Within a field, bits 1:0 choose the source, bit 3 turns the output driver on, and bit 2 is stored but has no effect. All 32 bits read back as written.
- R6: With the stop input low, a pin's source follows its field: code 0 selects the output latch bit, and codes 1, 2 and 3 select alternate sources 1, 2 and 3. The pin's output enable equals field bit 3.
- R7: With the stop input high, a pin whose mask bit is 0 behaves exactly as in R6.
- R8: With the stop input high, a pin whose mask bit is 1 drives its output latch bit with output enable 1, whatever its field holds.
- R9: The stop input acts in the same cycle, with no clock edge needed. When it falls, pins return to their configured behaviour with no latched state.
- R10: Reads from any offset other than 0x00, 0x10, 0x14 and 0x50 return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| estop_i | input | 1 | Global emergency stop, level-sensitive |
| alt1_i | input | 16 | Alternate source 1, one bit per pin |
| alt2_i | input | 16 | Alternate source 2, one bit per pin |
| alt3_i | input | 16 | Alternate source 3, one bit per pin |
| pin_out_o | output | 16 | Value driven on each pin |
| pin_oe_o | output | 16 | Output driver enable for each pin |

## Verification
Some checks run on every clock edge, pin by pin, and compare the pin outputs with the stored latch and mask:
- An overridden pin must carry its latch bit with its driver on.
- A pin that is not overridden must have a driver enable that follows its configuration bit.
- A mask write must appear in the register on the next cycle.
- Reserved and unmapped reads must return zero.

Other behaviours can only be shown by the bench scenarios:
- the decoding of each source code against three different alternate patterns;
- the independence of neighbouring fields;
- the same-cycle release when the stop input falls;
- the fact that writes to unmapped offsets leave every register untouched.

// File: rtl/gpio_estop_pkg.sv
package gpio_estop_pkg;

  // Register offsets (byte addresses within the port block)
  localparam int unsigned OFS_DOUT    = 'h00;
  localparam int unsigned OFS_CFG_LO  = 'h10;
  localparam int unsigned OFS_STOP_EN = 'h50;

  // Source codes inside a pin field
  localparam logic [1:0] SRC_LATCH = 2'd0;
  localparam logic [1:0] SRC_ALT1  = 2'd1;
  localparam logic [1:0] SRC_ALT2  = 2'd2;

  // Field layout: bit 3 drive, bit 2 spare, bits 1:0 source
  localparam int unsigned FLD_DRIVE_BIT = 3;

  // Normal (non-overridden) source selection for one pin
  function automatic logic pick_src(input logic [1:0] src, input logic latch,
                                    input logic a1, input logic a2, input logic a3);
    logic v;
    case (src)
      SRC_LATCH: v = latch;
      SRC_ALT1:  v = a1;
      SRC_ALT2:  v = a2;
      default:   v = a3;
    endcase
    return v;
  endfunction

  // Address of configuration register k
  function automatic int unsigned cfg_ofs(input int unsigned k);
    return OFS_CFG_LO + 4 * k;
  endfunction

endpackage

// File: rtl/gpio_estop_regs.sv
module gpio_estop_regs
  import gpio_estop_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned FW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NPINS-1:0]   dout_q,
  output logic [NPINS-1:0]   stop_en_q,
  output logic [2*NPINS-1:0] src_q,
  output logic [NPINS-1:0]   drive_q
);

  localparam int unsigned PPC  = DW / FW;
  localparam int unsigned NCFG = (NPINS + PPC - 1) / PPC;

  // Address decode, brought out as named wires for the checks
  logic            hit_dout;
  logic            hit_stop;
  logic [NCFG-1:0] hit_cfg;
  logic            hit_any;

  assign hit_dout = (bus_addr == AW'(OFS_DOUT));
  assign hit_stop = (bus_addr == AW'(OFS_STOP_EN));

  logic [DW-1:0] cfg_q [NCFG];

  genvar k;
  generate
    for (k = 0; k < NCFG; k++) begin : g_cfg
      assign hit_cfg[k] = (bus_addr == AW'(cfg_ofs(k)));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cfg_q[k] <= '0;
        else if (bus_wr && hit_cfg[k]) cfg_q[k] <= bus_wdata;
      end
    end
  endgenerate

  assign hit_any = hit_dout | hit_stop | (|hit_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      stop_en_q <= '0;
    end else if (bus_wr) begin
      if (hit_dout) dout_q    <= bus_wdata[NPINS-1:0];
      if (hit_stop) stop_en_q <= bus_wdata[NPINS-1:0];
    end
  end

  // Per-pin field extraction
  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_fld
      assign src_q[2*p +: 2] = cfg_q[p / PPC][(p % PPC) * FW +: 2];
      assign drive_q[p]      = cfg_q[p / PPC][(p % PPC) * FW + FLD_DRIVE_BIT];
    end
  endgenerate

  // Combinational readback
  always_comb begin
    bus_rdata = '0;
    if (hit_dout) bus_rdata[NPINS-1:0] = dout_q;
    if (hit_stop) bus_rdata[NPINS-1:0] = stop_en_q;
    for (int i = 0; i < NCFG; i++)
      if (hit_cfg[i]) bus_rdata = cfg_q[i];
  end

  // R2: a mask write is visible in the next cycle
  assert_stop_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_stop) |=> (stop_en_q == $past(bus_wdata[NPINS-1:0])));

  // R3: reserved bits of the mask register read zero
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stop |-> (bus_rdata[DW-1:NPINS] == '0));

  // R10: unmapped reads return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> (bus_rdata == '0));

  // R10: an unmapped write leaves the mask and latch unchanged
  assert_unmapped_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_any) |=> ($stable(stop_en_q) && $stable(dout_q)));

endmodule

// File: rtl/gpio_estop_pin.sv
module gpio_estop_pin
  import gpio_estop_pkg::*;
(
  input  logic [1:0] src,
  input  logic       drive,
  input  logic       latch,
  input  logic       alt1,
  input  logic       alt2,
  input  logic       alt3,
  input  logic       stop_en,
  input  logic       estop,
  output logic       ovr,
  output logic       pin_out,
  output logic       pin_oe
);

  logic norm_val;

  assign norm_val = pick_src(src, latch, alt1, alt2, alt3);
  assign ovr      = estop & stop_en;
  assign pin_out  = ovr ? latch : norm_val;
  assign pin_oe   = ovr | drive;

endmodule

// File: rtl/gpio_estop_port.sv
module gpio_estop_port
  import gpio_estop_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned FW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             estop_i,
  input  logic [NPINS-1:0] alt1_i,
  input  logic [NPINS-1:0] alt2_i,
  input  logic [NPINS-1:0] alt3_i,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_oe_o
);

  logic [NPINS-1:0]   dout_q;
  logic [NPINS-1:0]   stop_en_q;
  logic [2*NPINS-1:0] src_q;
  logic [NPINS-1:0]   drive_q;
  logic [NPINS-1:0]   ovr_w;

  gpio_estop_regs #(.NPINS(NPINS), .DW(DW), .AW(AW), .FW(FW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dout_q    (dout_q),
    .stop_en_q (stop_en_q),
    .src_q     (src_q),
    .drive_q   (drive_q)
  );

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      gpio_estop_pin u_pin (
        .src     (src_q[2*p +: 2]),
        .drive   (drive_q[p]),
        .latch   (dout_q[p]),
        .alt1    (alt1_i[p]),
        .alt2    (alt2_i[p]),
        .alt3    (alt3_i[p]),
        .stop_en (stop_en_q[p]),
        .estop   (estop_i),
        .ovr     (ovr_w[p]),
        .pin_out (pin_out_o[p]),
        .pin_oe  (pin_oe_o[p])
      );

      // R8: an overridden pin carries its latch bit with the driver on
      assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (estop_i && stop_en_q[p]) |-> (pin_out_o[p] == dout_q[p] && pin_oe_o[p]));

      // R7: without override the driver follows the field bit
      assert_keep_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(estop_i && stop_en_q[p]) |-> (pin_oe_o[p] == drive_q[p]));
    end
  endgenerate

  // R9: the override set is never wider than the mask
  assert_ovr_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_w & ~stop_en_q) == '0));

endmodule

// File: tb/tb_gpio_estop_port.sv
module tb_gpio_estop_port;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        estop_i = 0;
  logic [15:0] alt1_i = 16'h00FF;
  logic [15:0] alt2_i = 16'h0F0F;
  logic [15:0] alt3_i = 16'h3333;
  logic [15:0] pin_out_o;
  logic [15:0] pin_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench shadow of the programmed registers
  logic [15:0] m_dout = '0;
  logic [15:0] m_en = '0;
  logic [31:0] m_cfg [2];

  gpio_estop_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .estop_i(estop_i),
    .alt1_i(alt1_i), .alt2_i(alt2_i), .alt3_i(alt3_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  // Expected pin value and enable, restated arithmetically
  function automatic logic [31:0] expect_pins();
    logic [15:0] v, oe;
    for (int p = 0; p < 16; p++) begin
      int fld;
      int code;
      fld  = (m_cfg[p / 8] >> (4 * (p % 8))) & 32'hF;
      code = fld % 4;
      if (estop_i && m_en[p]) begin
        v[p] = m_dout[p]; oe[p] = 1'b1;
      end else begin
        if (code == 0)      v[p] = m_dout[p];
        else if (code == 1) v[p] = alt1_i[p];
        else if (code == 2) v[p] = alt2_i[p];
        else                v[p] = alt3_i[p];
        oe[p] = (fld >= 8);
      end
    end
    return {oe, v};
  endfunction

  task automatic pin_check(input string req);
    #1;
    check(req, {pin_oe_o, pin_out_o}, expect_pins());
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_cfg[0] = '0; m_cfg[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd_check("R1 dout", 8'h00, 32'h0);
    rd_check("R1 cfg lo", 8'h10, 32'h0);
    rd_check("R1 cfg hi", 8'h14, 32'h0);
    rd_check("R1 mask", 8'h50, 32'h0);
    check("R1 pins", {pin_oe_o, pin_out_o}, 32'h0);

    // R2 / R3: mask register, reserved bits
    wr(8'h50, 32'hFFFF_FFFF);
    rd_check("R3 reserved", 8'h50, 32'h0000_FFFF);
    wr(8'h50, 32'h1234_A5C3);
    rd_check("R2 mask rw", 8'h50, 32'h0000_A5C3);
    // R4: latch register
    wr(8'h00, 32'hABCD_3C5A);
    rd_check("R4 dout", 8'h00, 32'h0000_3C5A);
    // R5: configuration registers store all bits
    wr(8'h10, 32'hDEAD_BEEF);
    rd_check("R5 cfg lo", 8'h10, 32'hDEAD_BEEF);
    wr(8'h14, 32'h0123_4567);
    rd_check("R5 cfg hi", 8'h14, 32'h0123_4567);

    // R10: unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    rd_check("R10 rd 04", 8'h04, 32'h0);
    rd_check("R10 rd 54", 8'h54, 32'h0);
    rd_check("R10 keep dout", 8'h00, 32'h0000_3C5A);
    rd_check("R10 keep lo", 8'h10, 32'hDEAD_BEEF);
    rd_check("R10 keep hi", 8'h14, 32'h0123_4567);
    rd_check("R10 keep mask", 8'h50, 32'h0000_A5C3);

    // Sweep: mask pattern x base code x drive x stop level
    m_dout = 16'h3C5A;
    for (int e = 0; e < 3; e++) begin
      m_en = (e == 0) ? 16'h0000 : (e == 1) ? 16'hFFFF : 16'hA5C3;
      wr(8'h50, {16'h0, m_en});
      for (int s = 0; s < 4; s++) begin
        for (int d = 0; d < 2; d++) begin
          for (int k = 0; k < 2; k++) begin
            logic [31:0] w;
            w = '0;
            for (int j = 0; j < 8; j++) begin
              int p;
              p = k * 8 + j;
              w[4*j +: 2] = 2'((s + p) % 4);
              w[4*j + 2]  = p[1];
              w[4*j + 3]  = 1'(d) ^ p[0];
            end
            m_cfg[k] = w;
            wr(8'h10 + 8'(4 * k), w);
          end
          @(negedge clk);
          estop_i = 0;
          pin_check("R6 normal select");
          estop_i = 1;
          pin_check((e == 0) ? "R7 stop, mask clear" : "R8 stop, mask set");
          estop_i = 0;
        end
      end
    end

    // R9: same-cycle release and re-entry, with alternates changing
    @(negedge clk);
    estop_i = 1;
    pin_check("R9 enter");
    alt1_i = 16'hFF00; alt2_i = 16'hF0F0; alt3_i = 16'hCCCC;
    pin_check("R8 alt change ignored");
    estop_i = 0;
    pin_check("R9 release");
    @(negedge clk);
    pin_check("R9 no latch after edge");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule